// File: doc/BRIEF.md
# Indirect Interrupt Routing Register Window

This block is the software-visible register file of an I/O interrupt routing controller. The bus sees only two 32-bit locations. One is an 8-bit index select register. The other is a data window that reads or writes whichever internal register the latched index names. Behind the window sit three fixed words and up to 24 routing entries. The fixed words are an identification word, a read-only version word and a read-only arbitration word. Each routing entry is 64 bits wide and is reached as two independent 32-bit halves.

Software first writes an index to the select location. It then reads or writes the window location as often as needed. The block stores routing-entry contents without interpreting them. It only forces the documented reset pattern and keeps the read-only fields read-only.

The bus is a plain single-cycle register port, not a stream. A write completes in the cycle `bus_wr` is high. A read sampled with `bus_rd` high returns its data one cycle later with `bus_rvalid` high. Neither side can stall the other: there is no back-pressure and no ready signal. A read and a write may be issued in the same cycle.

Top module: `irq_route_regwin`

## Requirements
- R1: A write to bus address 0x00 (select location) latches `bus_wdata[7:0]` as the index. A read of 0x00 returns `{24'h0, index}`. The index resets to 0, and a select write alters no internal register.
- R2: A read issued with `bus_rd` in one cycle drives `bus_rvalid` high with its data in the next cycle. Whenever `bus_rvalid` is low, `bus_rdata` is zero.
- R3: A read or write of bus address 0x10 (window location) acts on the register named by the latched index. Index 0 is the identification word: bits 27:24 hold a writable 4-bit device tag that resets to `ID_RESET`, and every other bit reads 0.
- R4: Index 1 is read-only and reads `{8'h0, NUM_ENTRIES-1 in bits 23:16, 7'h0, VERSION in bits 8:0}`. Writes to it are ignored.
- R5: Index 2 is read-only and returns the arbitration tag in bits 27:24, with 0 elsewhere. It resets to `ID_RESET` and takes the written device tag whenever index 0 is written. A direct write to index 2 is ignored.
- R6: Routing entry n has its low half at index 0x10+2n and its high half at index 0x11+2n. A write to one half stores all 32 bits and leaves the other half and all other entries unchanged.
- R7: After reset every entry's low half reads 0x0001_0000 (mask bit 16 set) and its high half reads 0.
- R8: A window read of an unimplemented index (3 to 0x0F, and 0x10+2*NUM_ENTRIES upward) returns 0. A window write to such an index changes nothing.
- R9: Reads of bus addresses other than 0x00 and 0x10 return 0 (still with `bus_rvalid`). Writes to them are ignored.
- R10: When a window read and a window write to the same index occur in one cycle, the read returns the contents from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address of the access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |

## Verification
Directed sequences first cover reset contents: every entry half, the fixed words and the select readback. Constrained random traffic then mixes select writes, window writes and window reads over the whole 8-bit index space, plus stray bus addresses. A bench model predicts every read. Because some indices are writable, some are read-only and some are unimplemented, a mix-up between the three classes shows up as a data mismatch. Targeted writes to one entry half, followed by reads of its twin half and its neighbours, show whether the index arithmetic or the per-half enable has drifted. A same-cycle read and write shows whether the read port samples before or after the update.

// File: rtl/irw_pkg.sv
package irw_pkg;
  localparam int IDX_W      = 8;
  localparam int DATA_W     = 32;
  localparam int ENTRY_BASE = 16;
  localparam logic [DATA_W-1:0] ENTRY_LO_RST = 32'h0001_0000;
  localparam logic [DATA_W-1:0] ENTRY_HI_RST = 32'h0000_0000;

  typedef enum logic [2:0] {
    TGT_NONE  = 3'd0,
    TGT_ID    = 3'd1,
    TGT_VER   = 3'd2,
    TGT_ARB   = 3'd3,
    TGT_ENTRY = 3'd4
  } irw_tgt_e;
endpackage

// File: rtl/irw_bus_decode.sv
module irw_bus_decode #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] SEL_OFS = 8'h00,
  parameter logic [ADDR_W-1:0] WIN_OFS = 8'h10
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  output logic              sel_wr,
  output logic              sel_rd,
  output logic              win_wr,
  output logic              win_rd
);
  logic hit_sel, hit_win;

  always_comb begin
    hit_sel = (addr == SEL_OFS);
    hit_win = (addr == WIN_OFS);
    sel_wr  = wr_en && hit_sel;
    sel_rd  = rd_en && hit_sel;
    win_wr  = wr_en && hit_win;
    win_rd  = rd_en && hit_win;
  end
endmodule

// File: rtl/irw_index_map.sv
module irw_index_map
  import irw_pkg::*;
#(
  parameter int NUM_ENTRIES = 24,
  localparam int ENT_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic [IDX_W-1:0] idx,
  output irw_tgt_e         tgt,
  output logic [ENT_W-1:0] entry_num,
  output logic             hi_half
);
  localparam int ENTRY_END = ENTRY_BASE + 2 * NUM_ENTRIES;

  logic [IDX_W-1:0] off;

  always_comb begin
    off       = idx - IDX_W'(ENTRY_BASE);
    entry_num = ENT_W'(off >> 1);
    hi_half   = off[0];
    if (idx == 8'd0)
      tgt = TGT_ID;
    else if (idx == 8'd1)
      tgt = TGT_VER;
    else if (idx == 8'd2)
      tgt = TGT_ARB;
    else if ((int'(idx) >= ENTRY_BASE) && (int'(idx) < ENTRY_END))
      tgt = TGT_ENTRY;
    else
      tgt = TGT_NONE;
  end
endmodule

// File: rtl/irw_id_regs.sv
module irw_id_regs #(
  parameter logic [3:0] ID_RESET = 4'h0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [3:0] wr_tag,
  output logic [3:0] id_q,
  output logic [3:0] arb_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_q  <= ID_RESET;
      arb_q <= ID_RESET;
    end else if (we) begin
      id_q  <= wr_tag;
      arb_q <= wr_tag;
    end
  end

  // R3
  id_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(id_q));

  // R5
  arb_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (arb_q == $past(wr_tag)));
endmodule

// File: rtl/irw_entry_file.sv
module irw_entry_file
  import irw_pkg::*;
#(
  parameter int NUM_ENTRIES = 24,
  localparam int ENT_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ENT_W-1:0]  entry_num,
  input  logic              hi_half,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rd_word
);
  logic [NUM_ENTRIES-1:0][DATA_W-1:0] lo_q;
  logic [NUM_ENTRIES-1:0][DATA_W-1:0] hi_q;
  logic [NUM_ENTRIES-1:0]             ent_we;

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_ent
    assign ent_we[g] = we && (entry_num == ENT_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lo_q[g] <= ENTRY_LO_RST;
        hi_q[g] <= ENTRY_HI_RST;
      end else if (ent_we[g]) begin
        if (hi_half) hi_q[g] <= wdata;
        else         lo_q[g] <= wdata;
      end
    end
  end

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (entry_num == ENT_W'(i))
        rd_word = hi_half ? hi_q[i] : lo_q[i];
    end
  end

  // R6
  one_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ent_we));

  // R8
  entry_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> ($stable(lo_q) && $stable(hi_q)));
endmodule

// File: rtl/irq_route_regwin.sv
module irq_route_regwin
  import irw_pkg::*;
#(
  parameter int         NUM_ENTRIES = 24,
  parameter logic [8:0] VERSION     = 9'h020,
  parameter logic [3:0] ID_RESET    = 4'h0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  bus_addr,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        bus_rvalid
);
  localparam int ENT_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;
  localparam logic [7:0] MAX_ENTRY = 8'(NUM_ENTRIES - 1);

  logic              sel_wr, sel_rd, win_wr, win_rd;
  logic [IDX_W-1:0]  sel_q;
  irw_tgt_e          tgt;
  logic [ENT_W-1:0]  entry_num;
  logic              hi_half;
  logic [3:0]        id_q, arb_q;
  logic [DATA_W-1:0] ent_word, win_word, rd_next;
  logic [DATA_W-1:0] rdata_q;
  logic              rvalid_q;

  irw_bus_decode #(.ADDR_W(8), .SEL_OFS(8'h00), .WIN_OFS(8'h10)) u_dec (
    .addr(bus_addr), .wr_en(bus_wr), .rd_en(bus_rd),
    .sel_wr(sel_wr), .sel_rd(sel_rd), .win_wr(win_wr), .win_rd(win_rd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sel_q <= '0;
    else if (sel_wr) sel_q <= bus_wdata[IDX_W-1:0];
  end

  irw_index_map #(.NUM_ENTRIES(NUM_ENTRIES)) u_map (
    .idx(sel_q), .tgt(tgt), .entry_num(entry_num), .hi_half(hi_half)
  );

  irw_id_regs #(.ID_RESET(ID_RESET)) u_id (
    .clk(clk), .rst_n(rst_n),
    .we(win_wr && (tgt == TGT_ID)),
    .wr_tag(bus_wdata[27:24]),
    .id_q(id_q), .arb_q(arb_q)
  );

  irw_entry_file #(.NUM_ENTRIES(NUM_ENTRIES)) u_ent (
    .clk(clk), .rst_n(rst_n),
    .we(win_wr && (tgt == TGT_ENTRY)),
    .entry_num(entry_num), .hi_half(hi_half),
    .wdata(bus_wdata), .rd_word(ent_word)
  );

  always_comb begin
    unique case (tgt)
      TGT_ID:    win_word = {4'h0, id_q, 24'h0};
      TGT_VER:   win_word = {8'h0, MAX_ENTRY, 7'h0, VERSION};
      TGT_ARB:   win_word = {4'h0, arb_q, 24'h0};
      TGT_ENTRY: win_word = ent_word;
      default:   win_word = '0;
    endcase
    if (sel_rd)      rd_next = {24'h0, sel_q};
    else if (win_rd) rd_next = win_word;
    else             rd_next = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rdata_q  <= rd_next;
      rvalid_q <= bus_rd;
    end
  end

  assign bus_rdata  = rdata_q;
  assign bus_rvalid = rvalid_q;

  // R1
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_wr |=> $stable(sel_q));

  // R2
  rdata_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rvalid |-> (bus_rdata == '0));
endmodule

// File: tb/irq_route_regwin_tb.sv
module irq_route_regwin_tb;
  localparam int N = 24;
  localparam logic [7:0] A_SEL = 8'h00;
  localparam logic [7:0] A_WIN = 8'h10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 0, bus_rd = 0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;

  int checks = 0, fails = 0;

  logic [7:0]  sel_m;
  logic [3:0]  id_m;
  logic [31:0] lo_m [N];
  logic [31:0] hi_m [N];

  always #2.5 clk = ~clk;

  irq_route_regwin u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid)
  );

  function automatic logic [31:0] exp_win(input logic [7:0] idx);
    int e;
    if (idx == 8'd0) return {4'h0, id_m, 24'h0};
    if (idx == 8'd1) return {8'h0, 8'(N - 1), 7'h0, 9'h020};
    if (idx == 8'd2) return {4'h0, id_m, 24'h0};
    if (idx >= 8'h10 && int'(idx) < 16 + 2 * N) begin
      e = (int'(idx) - 16) / 2;
      return idx[0] ? hi_m[e] : lo_m[e];
    end
    return 32'h0;
  endfunction

  function automatic logic [31:0] exp_bus(input logic [7:0] a);
    if (a == A_SEL) return {24'h0, sel_m};
    if (a == A_WIN) return exp_win(sel_m);
    return 32'h0;
  endfunction

  task automatic model_write(input logic [7:0] a, input logic [31:0] d);
    int e;
    if (a == A_SEL) sel_m = d[7:0];
    else if (a == A_WIN) begin
      if (sel_m == 8'd0) id_m = d[27:24];
      else if (sel_m >= 8'h10 && int'(sel_m) < 16 + 2 * N) begin
        e = (int'(sel_m) - 16) / 2;
        if (sel_m[0]) hi_m[e] = d; else lo_m[e] = d;
      end
    end
  endtask

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    bus_wr = 0; bus_rd = 0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1; bus_rd = 0;
    @(posedge clk);
    model_write(a, d);
    idle();
  endtask

  task automatic rd(input logic [7:0] a, input string tag);
    logic [31:0] e;
    @(negedge clk);
    bus_addr = a; bus_rd = 1; bus_wr = 0;
    e = exp_bus(a);
    @(posedge clk); #1;
    check({tag, " rvalid"}, {31'h0, bus_rvalid}, 32'h1);
    check(tag, bus_rdata, e);
    idle();
  endtask

  task automatic win_rd(input logic [7:0] idx, input string tag);
    wr(A_SEL, {24'h0, idx});
    rd(A_WIN, tag);
  endtask

  task automatic win_wr(input logic [7:0] idx, input logic [31:0] d);
    wr(A_SEL, {24'h0, idx});
    wr(A_WIN, d);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] r, d, old;
    logic [7:0] idx;
    r = $urandom(32'h00C0FFEE);
    sel_m = 0; id_m = 0;
    for (int i = 0; i < N; i++) begin lo_m[i] = 32'h0001_0000; hi_m[i] = 0; end
    repeat (3) @(posedge clk);
    #1;
    check("R2 reset rvalid", {31'h0, bus_rvalid}, 32'h0);
    check("R2 reset rdata", bus_rdata, 32'h0);
    rst_n = 1;

    rd(A_SEL, "R1 select reset");
    for (int i = 0; i < 2 * N; i++) win_rd(8'(16 + i), "R7 entry reset");
    win_rd(8'd1, "R4 version");
    win_rd(8'd0, "R3 id reset");
    win_rd(8'd2, "R5 arb reset");

    win_wr(8'd0, 32'hFFFF_FFFF);
    win_rd(8'd0, "R3 id write mask");
    win_rd(8'd2, "R5 arb mirror");
    win_wr(8'd2, 32'h0500_0000);
    win_rd(8'd2, "R5 arb write ignored");
    win_wr(8'd1, 32'hFFFF_FFFF);
    win_rd(8'd1, "R4 version write ignored");
    win_wr(8'd0, 32'h0A00_0000);
    win_rd(8'd2, "R5 arb mirror second");

    win_wr(8'h14, 32'hDEAD_BEEF);
    win_rd(8'h15, "R6 high half untouched");
    win_rd(8'h14, "R6 low half stored");
    win_rd(8'h13, "R6 neighbour untouched");
    win_rd(8'h16, "R6 neighbour untouched");
    win_wr(8'h3F, 32'h1234_5678);
    win_rd(8'h3F, "R6 last entry high");
    win_rd(8'h3E, "R6 last entry low");

    foreach (lo_m[i]) if (i == 0) begin end
    win_wr(8'h40, 32'hFFFF_FFFF);
    win_rd(8'h40, "R8 past last entry");
    win_rd(8'h3F, "R8 write ignored");
    win_wr(8'h03, 32'hFFFF_FFFF);
    win_rd(8'h03, "R8 index 3");
    win_rd(8'h0F, "R8 index 0x0F");
    win_rd(8'hFF, "R8 index 0xFF");

    wr(A_SEL, 32'h0000_0022);
    wr(8'h04, 32'h0000_0033);
    rd(8'h04, "R9 stray read zero");
    rd(8'h14, "R9 stray read zero");
    rd(A_SEL, "R1 select after stray write");
    rd(A_SEL, "R1 select readback");

    wr(A_SEL, 32'h0000_0020);
    old = exp_win(8'h20);
    @(negedge clk);
    bus_addr = A_WIN; bus_wdata = 32'hCAFE_0001; bus_wr = 1; bus_rd = 1;
    @(posedge clk); #1;
    model_write(A_WIN, 32'hCAFE_0001);
    check("R10 read sees old", bus_rdata, old);
    idle();
    rd(A_WIN, "R10 new value after");

    for (int k = 0; k < 400; k++) begin
      r = $urandom;
      idx = (r[3:0] == 0) ? 8'($urandom) : 8'($urandom_range(0, 16 + 2 * N + 3));
      d = $urandom;
      case (r[6:4])
        3'd0, 3'd1: wr(A_SEL, {24'h0, idx});
        3'd2, 3'd3: wr(A_WIN, d);
        3'd4: rd(A_SEL, "R1 random select");
        3'd5: rd(8'($urandom_range(1, 15)) << 4 | 8'h4, "R9 random stray");
        default: rd(A_WIN, "R3 random window");
      endcase
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule